// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores that are in flight in an out-of-order core, in the order the program issued them. A store takes a slot when it is renamed and gets back a tag. When it executes, it fills that slot with its word address and data. Once the store is committed, the slot becomes eligible to write to the data cache. Writes leave the oldest end of the queue one at a time, and only when the cache accepts them. A flush cuts the queue back to a given tag and discards every store from that tag onward.

A load brings its word address and the tag it was given at allocation. That tag is the queue's tail at the moment the load was renamed, so every entry before it is older than the load. The block searches that older region and returns the data of the youngest store whose address is known and equal to the load's address. When no such store exists, it reports a miss and the load uses the cache value. A mode input sets how stores with an unknown address are treated. In optimistic mode they are skipped. In strict mode any such store that is older than the load holds the load back with a stall.

Every slot runs a small state machine with four states: FREE, PENDING (allocated, address unknown), READY (executed) and COMMITTED (waiting to drain). The transitions are:
- FREE→PENDING on allocate.
- PENDING→READY on execute.
- READY→COMMITTED on commit.
- COMMITTED→FREE on a cache write handshake.
- PENDING→FREE and READY→FREE on flush.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, `cache_wr_valid` is 0, and no load hits or stalls.
- R2: Allocations return consecutive tags that wrap modulo 2×DEPTH. After DEPTH entries are held, `alloc_ready` is 0 and a further allocate request neither changes `alloc_tag` nor adds an entry.
- R3: A load with `load_valid`=1 reports `fwd_hit`=1 and returns the data of the youngest executed store that is older than its tag and has an equal address.
- R4: If no older executed store matches, `fwd_hit` is 0 and the load uses the cache. With `load_valid`=0, both `fwd_hit` and `fwd_stall` are 0.
- R5: Stores at or after the load's tag take no part in its search.
- R6: With `strict_mode`=0, older stores that have not executed are skipped and `fwd_stall` stays 0.
- R7: With `strict_mode`=1, `fwd_stall` is 1 exactly when some older store has not executed, and `fwd_hit` is then 0.
- R8: A committed entry at the head drives `cache_wr_valid` together with its address and data. Each handshake retires one entry, in program order. Entries that are not committed never drive the cache port.
- R9: While `cache_wr_valid`=1 and `cache_wr_ready`=0, the cache request holds its address and data.
- R10: A flush sets the tail to `flush_tag`, so the next allocation gets that tag. Flushed stores no longer forward.
- R11: A store that is committed but not yet drained still forwards to younger loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strict_mode | input | 1 | 1: a load stalls on an older store with unknown address |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_ready | output | 1 | Queue has a free entry |
| alloc_tag | output | PTR_W | Tag given to the allocating store (current tail) |
| exec_valid | input | 1 | A store executes this cycle |
| exec_idx | input | IDX_W | Slot index of the executing store (low tag bits) |
| exec_addr | input | ADDR_W | Word address of the executing store |
| exec_data | input | DATA_W | Data of the executing store |
| commit_valid | input | 1 | Commit the oldest uncommitted store |
| flush_valid | input | 1 | Discard entries from `flush_tag` to the tail |
| flush_tag | input | PTR_W | New tail after a flush |
| load_valid | input | 1 | A load searches this cycle |
| load_tag | input | PTR_W | Tail value recorded when the load was allocated |
| load_addr | input | ADDR_W | Word address of the load |
| fwd_hit | output | 1 | An older matching store supplies the data |
| fwd_stall | output | 1 | Load must wait (strict mode) |
| fwd_data | output | DATA_W | Forwarded data, 0 on miss |
| cache_wr_valid | output | 1 | Head store is committed and ready to write |
| cache_wr_ready | input | 1 | Cache accepts the write this cycle |
| cache_wr_addr | output | ADDR_W | Address of the head store |
| cache_wr_data | output | DATA_W | Data of the head store |

## Verification
The forwarding outputs and the cache write request are combinational from slot state and the load inputs. The bench therefore samples them one time step after it changes a load input, and one time step after a clock edge for results that depend on state. Allocate, execute, commit and flush take effect at the first rising edge after the request, so `alloc_tag`, the new slot states and the next cache request are checked one step after that edge. A handshake retires the head at that same edge. Loads are swept over every tag between head and tail, four addresses and both modes. The expected values come from an independent age-ordered model of the queue.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // Lifecycle of one queue slot
    typedef enum logic [1:0] {
        SLOT_FREE      = 2'd0,
        SLOT_PENDING   = 2'd1,
        SLOT_READY     = 2'd2,
        SLOT_COMMITTED = 2'd3
    } slot_state_e;

endpackage

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              exec_i,
    input  logic              commit_i,
    input  logic              drain_i,
    input  logic              kill_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic [DATA_W-1:0] exec_data_i,
    output slot_state_e       state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    slot_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              capture;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc_i) state_d = SLOT_PENDING;
            end
            SLOT_PENDING: begin
                if (kill_i) begin
                    state_d = SLOT_FREE;
                end else if (exec_i) begin
                    state_d = SLOT_READY;
                    capture = 1'b1;
                end
            end
            SLOT_READY: begin
                if (kill_i)        state_d = SLOT_FREE;
                else if (commit_i) state_d = SLOT_COMMITTED;
            end
            SLOT_COMMITTED: begin
                if (drain_i) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // Payload captured when the store executes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= exec_addr_i;
            data_q <= exec_data_i;
        end
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        addr_o  = addr_q;
        data_o  = data_q;
    end

endmodule

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire_i,
    input  logic             commit_fire_i,
    input  logic             drain_fire_i,
    input  logic             flush_i,
    input  logic [PTR_W-1:0] flush_tag_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] cmt_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             full_o
);

    logic [PTR_W-1:0] head_q, cmt_q, tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            if (drain_fire_i)  head_q <= head_q + 1'b1;
            if (commit_fire_i) cmt_q  <= cmt_q + 1'b1;
            if (flush_i)           tail_q <= flush_tag_i;
            else if (alloc_fire_i) tail_q <= tail_q + 1'b1;
        end
    end

    always_comb begin
        head_o = head_q;
        cmt_o  = cmt_q;
        tail_o = tail_q;
        full_o = ((tail_q - head_q) == PTR_W'(DEPTH));
    end

endmodule

// File: rtl/sq_search.sv
module sq_search
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic                         load_valid_i,
    input  logic                         strict_i,
    input  logic [PTR_W-1:0]             head_i,
    input  logic [PTR_W-1:0]             load_tag_i,
    input  logic [ADDR_W-1:0]            load_addr_i,
    input  slot_state_e                  state_i [DEPTH],
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
    input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
    output logic                         hit_o,
    output logic                         stall_o,
    output logic [DATA_W-1:0]            data_o
);

    logic [PTR_W-1:0] older;
    logic [IDX_W-1:0] idx;

    // Walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        older   = load_tag_i - head_i;
        hit_o   = 1'b0;
        stall_o = 1'b0;
        data_o  = '0;
        idx     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_i[IDX_W-1:0] + IDX_W'(k);
            if (PTR_W'(k) < older) begin
                if (state_i[idx] == SLOT_PENDING) begin
                    if (strict_i) stall_o = 1'b1;
                end else if (state_i[idx] != SLOT_FREE &&
                             addr_i[idx] == load_addr_i) begin
                    hit_o  = 1'b1;
                    data_o = data_i[idx];
                end
            end
        end
        if (!load_valid_i || stall_o) begin
            hit_o  = 1'b0;
            data_o = '0;
        end
        if (!load_valid_i) stall_o = 1'b0;
    end

endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strict_mode,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_tag,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [DATA_W-1:0] exec_data,
    input  logic              commit_valid,
    input  logic              flush_valid,
    input  logic [PTR_W-1:0]  flush_tag,
    input  logic              load_valid,
    input  logic [PTR_W-1:0]  load_tag,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              fwd_hit,
    output logic              fwd_stall,
    output logic [DATA_W-1:0] fwd_data,
    output logic              cache_wr_valid,
    input  logic              cache_wr_ready,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data
);

    logic [PTR_W-1:0]             head_ptr, cmt_ptr, tail_ptr;
    logic                         full;
    logic                         alloc_fire, commit_fire, drain_fire;
    slot_state_e                  slot_state [DEPTH];
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [IDX_W-1:0]             head_idx, cmt_idx, tail_idx;

    assign head_idx = head_ptr[IDX_W-1:0];
    assign cmt_idx  = cmt_ptr[IDX_W-1:0];
    assign tail_idx = tail_ptr[IDX_W-1:0];

    assign alloc_fire  = alloc_valid && !full && !flush_valid;
    assign commit_fire = commit_valid && (cmt_ptr != tail_ptr) &&
                         (slot_state[cmt_idx] == SLOT_READY);
    assign drain_fire  = cache_wr_valid && cache_wr_ready;

    sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire_i (alloc_fire),
        .commit_fire_i(commit_fire),
        .drain_fire_i (drain_fire),
        .flush_i      (flush_valid),
        .flush_tag_i  (flush_tag),
        .head_o       (head_ptr),
        .cmt_o        (cmt_ptr),
        .tail_o       (tail_ptr),
        .full_o       (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [IDX_W-1:0] off;
        logic             kill;
        assign off  = IDX_W'(g) - flush_tag[IDX_W-1:0];
        assign kill = flush_valid && ({1'b0, off} < (tail_ptr - flush_tag));

        sq_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_fire && (tail_idx == IDX_W'(g))),
            .exec_i     (exec_valid && (exec_idx == IDX_W'(g))),
            .commit_i   (commit_fire && (cmt_idx == IDX_W'(g))),
            .drain_i    (drain_fire && (head_idx == IDX_W'(g))),
            .kill_i     (kill),
            .exec_addr_i(exec_addr),
            .exec_data_i(exec_data),
            .state_o    (slot_state[g]),
            .addr_o     (slot_addr[g]),
            .data_o     (slot_data[g])
        );
    end

    sq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
        .load_valid_i(load_valid),
        .strict_i    (strict_mode),
        .head_i      (head_ptr),
        .load_tag_i  (load_tag),
        .load_addr_i (load_addr),
        .state_i     (slot_state),
        .addr_i      (slot_addr),
        .data_i      (slot_data),
        .hit_o       (fwd_hit),
        .stall_o     (fwd_stall),
        .data_o      (fwd_data)
    );

    always_comb begin
        alloc_ready    = !full;
        alloc_tag      = tail_ptr;
        cache_wr_valid = (slot_state[head_idx] == SLOT_COMMITTED);
        cache_wr_addr  = slot_addr[head_idx];
        cache_wr_data  = slot_data[head_idx];
    end

endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strict_mode,
    input logic              alloc_valid,
    input logic              alloc_ready,
    input logic [PTR_W-1:0]  alloc_tag,
    input logic              flush_valid,
    input logic [PTR_W-1:0]  flush_tag,
    input logic              load_valid,
    input logic              fwd_hit,
    input logic              fwd_stall,
    input logic              cache_wr_valid,
    input logic              cache_wr_ready,
    input logic [ADDR_W-1:0] cache_wr_addr,
    input logic [DATA_W-1:0] cache_wr_data,
    input logic [PTR_W-1:0]  head_ptr,
    input logic [PTR_W-1:0]  cmt_ptr,
    input logic [PTR_W-1:0]  tail_ptr
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_ptr - head_ptr) <= PTR_W'(DEPTH)); // R2

    AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && !flush_valid) |=> (alloc_tag == $past(alloc_tag))); // R2

    AST_CMT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_ptr - head_ptr) <= (tail_ptr - head_ptr)); // R8

    AST_WR_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid |-> (cmt_ptr != head_ptr)); // R8

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && cache_wr_ready) |=> (head_ptr == PTR_W'($past(head_ptr) + 1'b1))); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && !cache_wr_ready) |=>
        (cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data))); // R9

    AST_STALL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_stall |-> !fwd_hit); // R7

    AST_OPT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !strict_mode |-> !fwd_stall); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (!fwd_hit && !fwd_stall)); // R4

    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (alloc_tag == $past(flush_tag))); // R10

endmodule

bind store_queue store_queue_chk #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strict_mode   (strict_mode),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .alloc_tag     (alloc_tag),
    .flush_valid   (flush_valid),
    .flush_tag     (flush_tag),
    .load_valid    (load_valid),
    .fwd_hit       (fwd_hit),
    .fwd_stall     (fwd_stall),
    .cache_wr_valid(cache_wr_valid),
    .cache_wr_ready(cache_wr_ready),
    .cache_wr_addr (cache_wr_addr),
    .cache_wr_data (cache_wr_data),
    .head_ptr      (head_ptr),
    .cmt_ptr       (cmt_ptr),
    .tail_ptr      (tail_ptr)
);

// File: tb/tb_store_queue.sv
module tb_store_queue;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;
    localparam int PTR_W  = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              rst_n = 1'b0;
    logic              strict_mode = 1'b0;
    logic              alloc_valid = 1'b0;
    logic              alloc_ready;
    logic [PTR_W-1:0]  alloc_tag;
    logic              exec_valid = 1'b0;
    logic [IDX_W-1:0]  exec_idx = '0;
    logic [ADDR_W-1:0] exec_addr = '0;
    logic [DATA_W-1:0] exec_data = '0;
    logic              commit_valid = 1'b0;
    logic              flush_valid = 1'b0;
    logic [PTR_W-1:0]  flush_tag = '0;
    logic              load_valid = 1'b0;
    logic [PTR_W-1:0]  load_tag = '0;
    logic [ADDR_W-1:0] load_addr = '0;
    logic              fwd_hit, fwd_stall;
    logic [DATA_W-1:0] fwd_data;
    logic              cache_wr_valid;
    logic              cache_wr_ready = 1'b0;
    logic [ADDR_W-1:0] cache_wr_addr;
    logic [DATA_W-1:0] cache_wr_data;

    store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .exec_data(exec_data), .commit_valid(commit_valid),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .load_valid(load_valid), .load_tag(load_tag), .load_addr(load_addr),
        .fwd_hit(fwd_hit), .fwd_stall(fwd_stall), .fwd_data(fwd_data),
        .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
        .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model, indexed by slot
    bit                m_known [DEPTH];
    logic [ADDR_W-1:0] m_addr  [DEPTH];
    logic [DATA_W-1:0] m_data  [DEPTH];
    logic [PTR_W-1:0]  m_head = '0;
    logic [PTR_W-1:0]  m_tail = '0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc;
        check("R2", "alloc_ready", 32'(alloc_ready), 32'd1);
        check("R2", "alloc_tag", 32'(alloc_tag), 32'(m_tail));
        alloc_valid = 1'b1;
        tick();
        alloc_valid = 1'b0;
        m_known[m_tail[IDX_W-1:0]] = 1'b0;
        m_tail = m_tail + 1'b1;
    endtask

    task automatic do_exec(input logic [PTR_W-1:0] tag, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d);
        exec_valid = 1'b1;
        exec_idx   = tag[IDX_W-1:0];
        exec_addr  = a;
        exec_data  = d;
        tick();
        exec_valid = 1'b0;
        m_known[tag[IDX_W-1:0]] = 1'b1;
        m_addr[tag[IDX_W-1:0]]  = a;
        m_data[tag[IDX_W-1:0]]  = d;
    endtask

    task automatic do_commit;
        commit_valid = 1'b1;
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic expect_load(input logic [PTR_W-1:0] lt, input logic [ADDR_W-1:0] la,
                               input bit strict, output bit e_hit, output bit e_stall,
                               output logic [DATA_W-1:0] e_data);
        logic [PTR_W-1:0] n;
        logic [IDX_W-1:0] idx;
        n = lt - m_head;
        e_hit = 1'b0;
        e_stall = 1'b0;
        e_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = m_head[IDX_W-1:0] + IDX_W'(k);
            if (k < int'(n)) begin
                if (!m_known[idx]) begin
                    if (strict) e_stall = 1'b1;
                end else if (m_addr[idx] == la) begin
                    e_hit  = 1'b1;
                    e_data = m_data[idx];
                end
            end
        end
        if (e_stall) begin
            e_hit  = 1'b0;
            e_data = '0;
        end
    endtask

    task automatic probe(input logic [PTR_W-1:0] lt, input logic [ADDR_W-1:0] la,
                         input bit strict, input string force_req);
        bit                e_hit, e_stall;
        logic [DATA_W-1:0] e_data;
        string             req;
        load_valid  = 1'b1;
        load_tag    = lt;
        load_addr   = la;
        strict_mode = strict;
        #1;
        expect_load(lt, la, strict, e_hit, e_stall, e_data);
        if (e_stall)     req = "R7";
        else if (e_hit)  req = "R3 R5";
        else if (strict) req = "R4";
        else             req = "R4 R6";
        if (force_req != "") req = force_req;
        check(req, "fwd_stall", 32'(fwd_stall), 32'(e_stall));
        check(req, "fwd_hit", 32'(fwd_hit), 32'(e_hit));
        if (e_hit) check(req, "fwd_data", 32'(fwd_data), 32'(e_data));
        load_valid = 1'b0;
    endtask

    task automatic sweep;
        logic [PTR_W-1:0] cnt;
        cnt = m_tail - m_head;
        for (int n = 0; n <= int'(cnt); n++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 2; s++)
                    probe(m_head + PTR_W'(n), ADDR_W'(a), s[0], "");
        #1;
        check("R4", "idle fwd_hit", 32'(fwd_hit), 32'd0);
        check("R4", "idle fwd_stall", 32'(fwd_stall), 32'd0);
    endtask

    task automatic check_head_write(input string req);
        logic [IDX_W-1:0] h;
        h = m_head[IDX_W-1:0];
        check(req, "cache_wr_valid", 32'(cache_wr_valid), 32'd1);
        check(req, "cache_wr_addr", 32'(cache_wr_addr), 32'(m_addr[h]));
        check(req, "cache_wr_data", 32'(cache_wr_data), 32'(m_data[h]));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_known[i] = 1'b0;
            m_addr[i]  = '0;
            m_data[i]  = '0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: empty after reset
        check("R1", "alloc_ready", 32'(alloc_ready), 32'd1);
        check("R1", "alloc_tag", 32'(alloc_tag), 32'd0);
        check("R1", "cache_wr_valid", 32'(cache_wr_valid), 32'd0);
        probe(4'd0, 8'd0, 1'b1, "R1");

        // R2: fill the queue in order, then push against full
        for (int k = 0; k < DEPTH; k++) do_alloc();
        check("R2", "alloc_ready full", 32'(alloc_ready), 32'd0);
        alloc_valid = 1'b1;
        tick();
        alloc_valid = 1'b0;
        check("R2", "alloc_tag when full", 32'(alloc_tag), 32'd8);
        check("R2", "alloc_ready still full", 32'(alloc_ready), 32'd0);

        // Execute out of order, leaving slot 5 unknown; sweep all loads
        for (int k = DEPTH - 1; k >= 0; k--)
            if (k != 5) do_exec(PTR_W'(k), ADDR_W'(k % 3), DATA_W'(16'h100 + k));
        sweep();

        // R8/R9: commit three, cache stalls
        for (int k = 0; k < 3; k++) do_commit();
        check_head_write("R8");
        tick();
        check_head_write("R9");
        tick();
        check_head_write("R9");
        // R11: committed entries still forward
        probe(4'd1, 8'd0, 1'b0, "R11");
        probe(4'd3, 8'd0, 1'b0, "R11");
        sweep();

        // R8: drain the committed entries in order
        cache_wr_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            check_head_write("R8");
            tick();
            m_head = m_head + 1'b1;
        end
        check("R8", "uncommitted head not written", 32'(cache_wr_valid), 32'd0);
        cache_wr_ready = 1'b0;

        // R10: flush back to tag 6
        flush_valid = 1'b1;
        flush_tag   = 4'd6;
        tick();
        flush_valid = 1'b0;
        m_tail = 4'd6;
        check("R10", "alloc_tag after flush", 32'(alloc_tag), 32'd6);
        check("R10", "alloc_ready after flush", 32'(alloc_ready), 32'd1);
        probe(4'd6, 8'd0, 1'b0, "R10");
        sweep();

        // Wrap the pointers and refill with new values
        for (int k = 0; k < 5; k++) do_alloc();
        check("R2", "alloc_ready wrapped full", 32'(alloc_ready), 32'd0);
        for (int k = 6; k < 11; k++)
            do_exec(PTR_W'(k), ADDR_W'((k + 1) % 4), DATA_W'(16'h200 + k));
        probe(4'd8, 8'd0, 1'b0, "R10");
        sweep();
        do_exec(4'd5, 8'd2, 16'h105);
        sweep();

        // R8/R9: commit everything, drain with the cache toggling ready
        for (int k = 0; k < DEPTH; k++) do_commit();
        for (int k = 0; k < DEPTH; k++) begin
            check_head_write("R9");
            tick();
            check_head_write("R9");
            cache_wr_ready = 1'b1;
            tick();
            cache_wr_ready = 1'b0;
            m_head = m_head + 1'b1;
        end
        check("R8", "drained cache_wr_valid", 32'(cache_wr_valid), 32'd0);
        check("R2", "drained alloc_ready", 32'(alloc_ready), 32'd1);
        check("R2", "drained alloc_tag", 32'(alloc_tag), 32'(m_tail));

        finish_run();
    end

endmodule